// File: doc/BRIEF.md
# Parameter Block Command Fetcher

This block is a bus-master engine that carries out one pipe buffer transfer from a single register write. Software first stores the byte address of a small command structure in memory through two 32-bit base registers (low and high half). A later write of any value to the trigger register makes the engine read the channel, size, buffer address and command words of that structure over a simple word-wide memory master port. It then hands a read-buffer or write-buffer command to the channel front end, waits for the returned status and stores that status into the result word of the same structure.

Two structure layouts are supported and chosen by a mode input: a narrow layout for 32-bit guests, where every field is one 32-bit word, and a wide layout for 64-bit guests, where channel and buffer address are 64-bit and naturally aligned. Command words other than the two buffer commands are not forwarded; the engine writes an error code into the result word instead. The buffer data movement itself happens elsewhere.

Top module: `param_cmd_fetcher`

## Requirements
- R1: While reset is held, `busy`, `memReq` and `cmdValid` are 0.
- R2: A write with `regSel` = 2 (trigger) while idle starts one operation whatever `regWdata` holds; `busy` is 1 from the cycle after that write until the result write-back is acknowledged.
- R3: A trigger write that arrives while `busy` is 1 is ignored: the running operation issues exactly one command and one write-back, and no further operation follows.
- R4: With `wideMode` = 0 the structure is read at byte offsets 0 (channel), 4 (size), 8 (buffer address) and 12 (command); the result goes to offset 16; the upper 32 bits of `cmdChannel` and `cmdBufAddr` are 0; the flags word at offset 20 is never written.
- R5: With `wideMode` = 1 the engine reads channel low/high at offsets 0/4, size at 8, buffer address low/high at 16/20 and command at 24; the result goes to offset 28; the flags word at offset 32 and the pad word at 12 are never written.
- R6: `regSel` = 0 writes the low and `regSel` = 1 the high half of the 64-bit structure base; the base is captured at the trigger, so base writes during an operation affect only later ones.
- R7: Memory accesses are issued one at a time: `memReq` with stable `memAddr` and `memWe` is held until `memAck`; an operation makes exactly 4 (narrow) or 6 (wide) reads and exactly one write.
- R8: Command word 4 (write buffer) or 5 (read buffer) produces one single-cycle `cmdValid` pulse with `cmdIsRead` = 0 or 1 respectively and with the fetched channel, size and buffer address on the command outputs.
- R9: The `stsValue` presented with `stsValid` while the engine waits is written to the result word; `busy` falls in the cycle after that write is acknowledged.
- R10: Any other command word produces no `cmdValid` and writes 32'hFFFF_FFFF into the result word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base low, 1 base high, 2 trigger |
| regWdata | input | 32 | Register write data |
| wideMode | input | 1 | 1 selects the 64-bit structure layout |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 for the result write, 0 for fetch reads |
| memAddr | output | 64 | Byte address of the word accessed |
| memWdata | output | 32 | Write data (result word) |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| cmdValid | output | 1 | One-cycle command strobe to the channel front end |
| cmdIsRead | output | 1 | 1 for read buffer, 0 for write buffer |
| cmdChannel | output | 64 | Fetched channel value |
| cmdSize | output | 32 | Fetched buffer size |
| cmdBufAddr | output | 64 | Fetched buffer address |
| stsValid | input | 1 | Status strobe from the front end |
| stsValue | input | 32 | Status value |

## Verification
A wrong step counter or layout decode shows up at the memory port within the same operation as a fetch from the wrong offset, a wrong read count, or fields on the command outputs that differ from the planted structure, and the bench compares each of these at the end of every operation. A fault in the state register shows as `busy` failing to fall within a few hundred cycles, a second command pulse, or a result written to a location other than the result field of the latched base. A wrong capture of the base shows as a high address half that differs from the one programmed before the trigger, checked on every memory access.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned PTR_W  = 2 * WORD_W;
  localparam int unsigned OFS_W  = 6;
  localparam int unsigned STEP_W = 3;
  localparam int unsigned SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_BASE_LO = 2'd0;
  localparam logic [SEL_W-1:0] SEL_BASE_HI = 2'd1;
  localparam logic [SEL_W-1:0] SEL_TRIGGER = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_WAIT,
    ST_WBACK
  } fsmState_t;

  typedef enum logic [2:0] {
    FLD_CH_LO,
    FLD_CH_HI,
    FLD_SIZE,
    FLD_AD_LO,
    FLD_AD_HI,
    FLD_CMD
  } fieldSel_t;

  typedef struct packed {
    logic             latchBase;
    logic             capture;
    fieldSel_t        field;
    logic [OFS_W-1:0] offset;
    logic             loadStatus;
    logic             forceErr;
  } ctrlStrobe_t;

  function automatic logic [STEP_W-1:0] lastStep(input logic wide);
    return wide ? 3'd5 : 3'd3;
  endfunction

  function automatic fieldSel_t stepField(input logic wide, input logic [STEP_W-1:0] step);
    fieldSel_t f;
    if (!wide) begin
      case (step)
        3'd0:    f = FLD_CH_LO;
        3'd1:    f = FLD_SIZE;
        3'd2:    f = FLD_AD_LO;
        default: f = FLD_CMD;
      endcase
    end else begin
      case (step)
        3'd0:    f = FLD_CH_LO;
        3'd1:    f = FLD_CH_HI;
        3'd2:    f = FLD_SIZE;
        3'd3:    f = FLD_AD_LO;
        3'd4:    f = FLD_AD_HI;
        default: f = FLD_CMD;
      endcase
    end
    return f;
  endfunction

  function automatic logic [OFS_W-1:0] stepOffset(input logic wide, input logic [STEP_W-1:0] step);
    logic [OFS_W-1:0] o;
    if (!wide) begin
      o = {1'b0, step, 2'b00};
    end else begin
      case (step)
        3'd0:    o = 6'd0;
        3'd1:    o = 6'd4;
        3'd2:    o = 6'd8;
        3'd3:    o = 6'd16;
        3'd4:    o = 6'd20;
        default: o = 6'd24;
      endcase
    end
    return o;
  endfunction

  function automatic logic [OFS_W-1:0] resultOffset(input logic wide);
    return wide ? 6'd28 : 6'd16;
  endfunction

endpackage

// File: rtl/pfetch_ctrl.sv
module pfetch_ctrl
  import pfetch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        wideMode,
  input  logic        memAck,
  input  logic        stsValid,
  input  logic        cmdLegal,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        cmdValid,
  output logic        busy
);

  fsmState_t         state, nextState;
  logic [STEP_W-1:0] step, nextStep;
  logic              opWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      step   <= '0;
      opWide <= 1'b0;
    end else begin
      state <= nextState;
      step  <= nextStep;
      if (state == ST_IDLE && trigger) begin
        opWide <= wideMode;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.field      = stepField(opWide, step);
    strobe.offset     = stepOffset(opWide, step);
    memReq            = 1'b0;
    memWe             = 1'b0;
    cmdValid          = 1'b0;
    nextState         = state;
    nextStep          = step;
    case (state)
      ST_IDLE: begin
        if (trigger) begin
          strobe.latchBase = 1'b1;
          nextState        = ST_FETCH;
          nextStep         = '0;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capture = 1'b1;
          if (step == lastStep(opWide)) begin
            nextState = ST_CHECK;
          end else begin
            nextStep = step + 3'd1;
          end
        end
      end
      ST_CHECK: begin
        if (cmdLegal) begin
          cmdValid  = 1'b1;
          nextState = ST_WAIT;
        end else begin
          strobe.forceErr = 1'b1;
          nextState       = ST_WBACK;
        end
      end
      ST_WAIT: begin
        if (stsValid) begin
          strobe.loadStatus = 1'b1;
          nextState         = ST_WBACK;
        end
      end
      ST_WBACK: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.offset = resultOffset(opWide);
        if (memAck) begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pfetch_dpath.sv
module pfetch_dpath
  import pfetch_pkg::*;
#(
  parameter logic [WORD_W-1:0] WR_CODE  = 32'd4,
  parameter logic [WORD_W-1:0] RD_CODE  = 32'd5,
  parameter logic [WORD_W-1:0] ERR_CODE = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [WORD_W-1:0] regWdata,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] stsValue,
  output logic [PTR_W-1:0]  memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [PTR_W-1:0]  cmdChannel,
  output logic [WORD_W-1:0] cmdSize,
  output logic [PTR_W-1:0]  cmdBufAddr,
  output logic              cmdIsRead,
  output logic              cmdLegal
);

  localparam int unsigned HALVES = PTR_W / WORD_W;

  logic [WORD_W-1:0] baseLo, baseHi;
  logic [PTR_W-1:0]  opBase;
  logic [WORD_W-1:0] chanHalf [HALVES];
  logic [WORD_W-1:0] addrHalf [HALVES];
  logic [WORD_W-1:0] sizeR, cmdR, resultR;

  // Software-visible base registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLo <= '0;
      baseHi <= '0;
    end else if (regWe) begin
      if (regSel == SEL_BASE_LO) baseLo <= regWdata;
      if (regSel == SEL_BASE_HI) baseHi <= regWdata;
    end
  end

  // Base snapshot taken when an operation starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opBase <= '0;
    end else if (strobe.latchBase) begin
      opBase <= {baseHi, baseLo};
    end
  end

  // Field capture; 64-bit fields are assembled half by half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int h = 0; h < HALVES; h++) begin
        chanHalf[h] <= '0;
        addrHalf[h] <= '0;
      end
      sizeR <= '0;
      cmdR  <= '0;
    end else if (strobe.latchBase) begin
      for (int h = 0; h < HALVES; h++) begin
        chanHalf[h] <= '0;
        addrHalf[h] <= '0;
      end
      sizeR <= '0;
      cmdR  <= '0;
    end else if (strobe.capture) begin
      for (int h = 0; h < HALVES; h++) begin
        if (strobe.field == ((h == 0) ? FLD_CH_LO : FLD_CH_HI)) chanHalf[h] <= memRdata;
        if (strobe.field == ((h == 0) ? FLD_AD_LO : FLD_AD_HI)) addrHalf[h] <= memRdata;
      end
      if (strobe.field == FLD_SIZE) sizeR <= memRdata;
      if (strobe.field == FLD_CMD)  cmdR  <= memRdata;
    end
  end

  // Result word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultR <= '0;
    end else if (strobe.forceErr) begin
      resultR <= ERR_CODE;
    end else if (strobe.loadStatus) begin
      resultR <= stsValue;
    end
  end

  genvar g;
  generate
    for (g = 0; g < HALVES; g++) begin : g_half
      assign cmdChannel[g*WORD_W +: WORD_W] = chanHalf[g];
      assign cmdBufAddr[g*WORD_W +: WORD_W] = addrHalf[g];
    end
  endgenerate

  assign memAddr   = opBase + {{(PTR_W-OFS_W){1'b0}}, strobe.offset};
  assign memWdata  = resultR;
  assign cmdSize   = sizeR;
  assign cmdIsRead = (cmdR == RD_CODE);
  assign cmdLegal  = (cmdR == RD_CODE) || (cmdR == WR_CODE);

endmodule

// File: rtl/param_cmd_fetcher.sv
module param_cmd_fetcher
  import pfetch_pkg::*;
#(
  parameter logic [WORD_W-1:0] WR_CODE  = 32'd4,
  parameter logic [WORD_W-1:0] RD_CODE  = 32'd5,
  parameter logic [WORD_W-1:0] ERR_CODE = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              wideMode,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [PTR_W-1:0]  memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck,
  output logic              cmdValid,
  output logic              cmdIsRead,
  output logic [PTR_W-1:0]  cmdChannel,
  output logic [WORD_W-1:0] cmdSize,
  output logic [PTR_W-1:0]  cmdBufAddr,
  input  logic              stsValid,
  input  logic [WORD_W-1:0] stsValue
);

  ctrlStrobe_t strobe;
  logic        cmdLegal;
  logic        trigger;

  assign trigger = regWe && (regSel == SEL_TRIGGER);

  pfetch_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .wideMode (wideMode),
    .memAck   (memAck),
    .stsValid (stsValid),
    .cmdLegal (cmdLegal),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWe    (memWe),
    .cmdValid (cmdValid),
    .busy     (busy)
  );

  pfetch_dpath #(
    .WR_CODE  (WR_CODE),
    .RD_CODE  (RD_CODE),
    .ERR_CODE (ERR_CODE)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .strobe     (strobe),
    .memRdata   (memRdata),
    .stsValue   (stsValue),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .cmdChannel (cmdChannel),
    .cmdSize    (cmdSize),
    .cmdBufAddr (cmdBufAddr),
    .cmdIsRead  (cmdIsRead),
    .cmdLegal   (cmdLegal)
  );

endmodule

// File: rtl/pfetch_checker.sv
module pfetch_checker
  import pfetch_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             memReq,
  input logic             memWe,
  input logic [PTR_W-1:0] memAddr,
  input logic             memAck,
  input logic             cmdValid
);

  // R1: quiet outputs during reset
  always_comb begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!busy && !memReq && !cmdValid);
    end
  end

  // R7: request held with stable address and direction until acknowledged
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R7: a write is always part of a request
  a_r7_write_in_request: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R2: memory activity only while busy
  a_r2_request_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R8: the command strobe lasts one cycle and never overlaps memory traffic
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  a_r8_cmd_alone: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy && !memReq);

  // R9: busy ends only after an acknowledged write-back
  a_r9_busy_ends_on_wb: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memReq && memWe && memAck));

endmodule

bind param_cmd_fetcher pfetch_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memAck   (memAck),
  .cmdValid (cmdValid)
);

// File: tb/param_cmd_fetcher_tb_top.sv
module param_cmd_fetcher_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic        wideMode = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        stsValid = 1'b0;
  logic [31:0] stsValue = '0;

  logic        busy, memReq, memWe, cmdValid, cmdIsRead;
  logic [63:0] memAddr, cmdChannel, cmdBufAddr;
  logic [31:0] memWdata, cmdSize;

  param_cmd_fetcher dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .wideMode(wideMode), .busy(busy), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .cmdValid(cmdValid), .cmdIsRead(cmdIsRead), .cmdChannel(cmdChannel),
    .cmdSize(cmdSize), .cmdBufAddr(cmdBufAddr), .stsValid(stsValid), .stsValue(stsValue)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mem [0:255];
  int          rdCount = 0, wrCount = 0, hiErr = 0, lastWrIdx = -1;
  logic [31:0] expHi = '0;
  int          cmdCount = 0;
  logic [63:0] seenCh = '0, seenAd = '0;
  logic [31:0] seenSize = '0;
  logic        seenRead = 1'b0;

  initial forever #4 clk = ~clk;

  function automatic logic [31:0] stsFor(input logic [31:0] sz, input logic [31:0] chLo);
    return sz ^ {chLo[30:0], 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory slave with random acknowledge latency
  initial forever begin
    int unsigned lat;
    @(negedge clk);
    memAck = 1'b0;
    if (memReq && rstN) begin
      lat = $urandom_range(0, 3);
      repeat (lat) @(negedge clk);
      if (memAddr[63:32] != expHi) hiErr++;
      if (memWe) begin
        mem[memAddr[9:2]] = memWdata;
        wrCount++;
        lastWrIdx = int'(memAddr[9:2]);
      end else begin
        memRdata = mem[memAddr[9:2]];
        rdCount++;
      end
      memAck = 1'b1;
    end
  end

  // Channel front end model
  initial forever begin
    int unsigned lat;
    @(negedge clk);
    stsValid = 1'b0;
    if (cmdValid) begin
      cmdCount++;
      seenCh   = cmdChannel;
      seenAd   = cmdBufAddr;
      seenSize = cmdSize;
      seenRead = cmdIsRead;
      lat = 1 + $urandom_range(0, 3);
      repeat (lat) @(negedge clk);
      stsValue = stsFor(seenSize, seenCh[31:0]);
      stsValid = 1'b1;
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic runOp(input bit wide, input logic [31:0] code, input int slot, input bit poke);
    int b, resIdx, flagIdx, rd0, wr0, cmd0;
    logic [31:0] hi, sz, flag, expRes;
    logic [63:0] ch, ad, expCh, expAd;
    bit legal;
    int n;
    b  = slot * 16;
    hi = $urandom;
    ch = {$urandom, $urandom} | 64'h1;
    ad = {$urandom, $urandom};
    sz = $urandom_range(1, 4096);
    flag = $urandom;
    for (int i = 0; i < 16; i++) mem[b+i] = 32'hA5A5_0000 + i;
    if (!wide) begin
      mem[b] = ch[31:0]; mem[b+1] = sz; mem[b+2] = ad[31:0]; mem[b+3] = code;
      mem[b+4] = 32'hDEAD_BEEF; mem[b+5] = flag;
      resIdx = b + 4; flagIdx = b + 5;
      expCh = {32'h0, ch[31:0]}; expAd = {32'h0, ad[31:0]};
    end else begin
      mem[b] = ch[31:0]; mem[b+1] = ch[63:32]; mem[b+2] = sz;
      mem[b+4] = ad[31:0]; mem[b+5] = ad[63:32]; mem[b+6] = code;
      mem[b+7] = 32'hDEAD_BEEF; mem[b+8] = flag;
      resIdx = b + 7; flagIdx = b + 8;
      expCh = ch; expAd = ad;
    end
    legal  = (code == 32'd4) || (code == 32'd5);
    expRes = legal ? stsFor(sz, ch[31:0]) : 32'hFFFF_FFFF;
    wideMode = wide;
    regWrite(2'd0, b * 4);
    regWrite(2'd1, hi);
    expHi = hi;
    rd0 = rdCount; wr0 = wrCount; cmd0 = cmdCount;
    regWrite(2'd2, $urandom);
    check(busy == 1'b1, "R2", "busy after trigger", 64'(busy), 64'd1);
    if (poke) begin
      regWrite(2'd2, $urandom);
      regWrite(2'd0, 32'h0000_0300);
      regWrite(2'd1, ~hi);
    end
    n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    check(!busy, "R9", "busy cleared", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    check(!busy && !memReq, "R3", "stays idle after op", 64'({busy, memReq}), 64'd0);
    check(cmdCount - cmd0 == (legal ? 1 : 0), legal ? "R8" : "R10", "command pulses",
          64'(cmdCount - cmd0), legal ? 64'd1 : 64'd0);
    if (legal) begin
      check(seenCh == expCh, wide ? "R5" : "R4", "channel", seenCh, expCh);
      check(seenAd == expAd, wide ? "R5" : "R4", "buffer address", seenAd, expAd);
      check(seenSize == sz, "R8", "size", 64'(seenSize), 64'(sz));
      check(seenRead == (code == 32'd5), "R8", "read flag", 64'(seenRead), 64'(code == 32'd5));
    end
    check(mem[resIdx] == expRes, legal ? "R9" : "R10", "result word", 64'(mem[resIdx]), 64'(expRes));
    check(mem[flagIdx] == flag, wide ? "R5" : "R4", "flags untouched", 64'(mem[flagIdx]), 64'(flag));
    check(wrCount - wr0 == 1 && lastWrIdx == resIdx, "R7", "single write-back location",
          64'(lastWrIdx), 64'(resIdx));
    check(rdCount - rd0 == (wide ? 6 : 4), "R7", "fetch reads", 64'(rdCount - rd0), wide ? 64'd6 : 64'd4);
    check(hiErr == 0, "R6", "base high half used", 64'(hiErr), 64'd0);
    hiErr = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !memReq && !cmdValid, "R1", "reset outputs",
          64'({busy, memReq, cmdValid}), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // directed cases
    runOp(1'b0, 32'd4, 0, 1'b0);
    runOp(1'b0, 32'd5, 1, 1'b0);
    runOp(1'b1, 32'd4, 2, 1'b0);
    runOp(1'b1, 32'd5, 3, 1'b0);
    runOp(1'b0, 32'd0, 0, 1'b0);
    runOp(1'b1, 32'hFFFF_FFFF, 1, 1'b0);
    runOp(1'b0, 32'd6, 2, 1'b0);
    runOp(1'b0, 32'd5, 3, 1'b1);
    runOp(1'b1, 32'd4, 0, 1'b1);
    // constrained random
    for (int k = 0; k < 40; k++) begin
      int unsigned pick;
      logic [31:0] code;
      pick = $urandom_range(0, 7);
      if (pick < 3)       code = 32'd4;
      else if (pick < 6)  code = 32'd5;
      else if (pick == 6) code = $urandom;
      else                code = 32'd3;
      runOp(1'($urandom_range(0, 1)), code, int'($urandom_range(0, 3)), $urandom_range(0, 3) == 0);
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule